// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block supervises a host microcontroller. The host proves it is alive by writing one fixed refresh key into the watchdog register before a timeout period runs out. Each correct write restarts the period. A period that ends without a correct write raises the `wd` output. After that, `wd` inverts at the end of every further period, so the host sees a steady square wave until it writes the key again.

Time is measured in falling edges of a slow timing input `tick_in`. The default is an 8 kHz frame pulse with 4096 edges per period, which gives 512 ms. `tick_in` is synchronised into the `clk` domain, and the count advances once per falling edge found there.

An active-low power reset `rst_n` acts asynchronously. While it is low, `wd` is high. When it rises, `wd` drops at once and counting starts from zero. Register writes use a valid/ready pair. The block never applies back-pressure while out of reset, so `wr_ready` simply mirrors the reset state. A beat is taken in every `clk` cycle where `wr_valid` and `wr_ready` are both high.

Top module: `keyed_wdog`

## Requirements
- R1: While `rst_n` is low, `wd` is 1 and `wr_ready` is 0, whatever the other inputs do.
- R2: When `rst_n` rises, `wd` goes to 0 without waiting for a `clk` edge, and the period count starts from zero.
- R3: The count advances only on a 1-to-0 transition of `tick_in`. Holding `tick_in` high, or a rising transition, does not advance it.
- R4: If no correct write is accepted, `wd` rises on the PERIOD_TICKS-th falling edge of `tick_in` after the count last started.
- R5: An accepted write whose bits [4:0] equal 5'b01010 restarts the count from zero and forces `wd` to 0. Bits above bit 4 are ignored.
- R6: An accepted write with any other value in bits [4:0] does not restart the count and does not change `wd`. The period still expires on time. A correct write later in the same period cancels the failure.
- R7: After a failure, `wd` inverts at every period end until a correct write is accepted.
- R8: `wr_ready` is 1 at all times when `rst_n` is high, so every valid beat is accepted in its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low power reset |
| tick_in | input | 1 | Slow timing input; each falling edge advances the count |
| wr_valid | input | 1 | Write beat to the watchdog register is present |
| wr_ready | output | 1 | Block can accept a write beat (high whenever out of reset) |
| wr_data | input | DATA_W | Write data; bits [4:0] are compared with the key |
| wd | output | 1 | Watchdog output to the host reset pin |

## Verification
The bench targets the following corner cases:

- **Key mask.** It writes keys that differ only in the don't-care upper bits, and bad keys that differ only in bit 4. A compare of the wrong width either rejects a valid refresh, which raises `wd` early, or accepts a bad one, which holds `wd` low.
- **Bad write restarting the count.** It writes a wrong key one edge before expiry and checks that `wd` still rises on time. If the bad write restarted the count, that rise would slip by a whole period.
- **Edge sense and toggling.** It holds `tick_in` high across a period boundary. It then runs several periods in the alarm state. A rising-edge counter fires early. A design that latches `wd` high stays high instead of inverting.
- **Reset timing.** It checks that `wd` rises the moment `rst_n` falls and drops the moment it rises, with no `clk` edge in between. A design with a synchronous reset gets this wrong.

// File: rtl/kwdog_pkg.sv
package kwdog_pkg;
  localparam int KEY_W = 5;
  localparam logic [KEY_W-1:0] REFRESH_KEY = 5'b01010;

  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_GOOD = 2'd1,
    WR_BAD  = 2'd2
  } wr_kind_e;
endpackage

// File: rtl/kwdog_tick_sync.sv
module kwdog_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick_fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= tick_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], tick_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign tick_fall = last_q & ~sync_q[STAGES-1];

  // R3
  fall_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fall |=> !tick_fall);
endmodule

// File: rtl/kwdog_key_check.sv
module kwdog_key_check
  import kwdog_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              wr_fire,
  input  logic [DATA_W-1:0] wr_data,
  output wr_kind_e          kind
);
  localparam logic [DATA_W-1:0] KEY_EXT  = DATA_W'(REFRESH_KEY);
  localparam logic [DATA_W-1:0] KEY_MASK = DATA_W'((1 << KEY_W) - 1);

  logic key_match;

  assign key_match = ((wr_data ^ KEY_EXT) & KEY_MASK) == '0;

  always_comb begin
    if (!wr_fire)       kind = WR_NONE;
    else if (key_match) kind = WR_GOOD;
    else                kind = WR_BAD;
  end
endmodule

// File: rtl/kwdog_period_ctr.sv
module kwdog_period_ctr #(
  parameter int PERIOD_TICKS = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic advance,
  output logic period_end
);
  localparam int CNT_W = (PERIOD_TICKS > 2) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last    = cnt_q == LAST;
  assign period_end = advance & at_last & ~restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (advance)  cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt_q == '0);
  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> cnt_q == '0);
  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !restart) |=> $stable(cnt_q));
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kwdog_pkg::*;
#(
  parameter int PERIOD_TICKS = 4096,
  parameter int DATA_W       = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wd
);
  logic     tick_fall;
  logic     period_end;
  logic     wr_fire;
  wr_kind_e wr_kind;
  logic     refresh;
  logic     wd_q;

  assign wr_ready = rst_n;
  assign wr_fire  = wr_valid & wr_ready;
  assign refresh  = wr_kind == WR_GOOD;

  kwdog_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_in   (tick_in),
    .tick_fall (tick_fall)
  );

  kwdog_key_check #(.DATA_W(DATA_W)) u_key (
    .wr_fire (wr_fire),
    .wr_data (wr_data),
    .kind    (wr_kind)
  );

  kwdog_period_ctr #(.PERIOD_TICKS(PERIOD_TICKS)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (refresh),
    .advance    (tick_fall),
    .period_end (period_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wd_q <= 1'b0;
    else if (refresh)    wd_q <= 1'b0;
    else if (period_end) wd_q <= ~wd_q;
  end

  assign wd = ~rst_n | wd_q;

  // R5
  refresh_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> !wd);
  // R7
  rise_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_q) |-> $past(period_end));
  // R6
  bad_key_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kind == WR_BAD && !period_end) |=> $stable(wd_q));
  // R8
  kind_needs_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_kind != WR_NONE) |-> (wr_valid && wr_ready));
endmodule

// File: tb/sim_keyed_wdog.sv
module sim_keyed_wdog;
  localparam int PT = 8;
  localparam int NV = 18;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_in = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready;
  logic       wd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  keyed_wdog #(.PERIOD_TICKS(PT), .DATA_W(8), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .wd(wd)
  );

  // {op(1: write, 0: ticks), data, tick count, expected wd, requirement}
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'd7, 1'b0, 4'd4},  // R4 one edge short of expiry
    {1'b1, 8'h0A, 8'd0, 1'b0, 4'd5},  // R5 exact key
    {1'b0, 8'h00, 8'd7, 1'b0, 4'd5},  // R5 count restarted
    {1'b1, 8'hEA, 8'd0, 1'b0, 4'd5},  // R5 upper bits ignored
    {1'b0, 8'h00, 8'd7, 1'b0, 4'd5},
    {1'b1, 8'h0B, 8'd0, 1'b0, 4'd6},  // R6 bad key, wd unchanged
    {1'b0, 8'h00, 8'd1, 1'b1, 4'd6},  // R6 period still expires
    {1'b0, 8'h00, 8'd7, 1'b1, 4'd7},
    {1'b0, 8'h00, 8'd1, 1'b0, 4'd7},  // R7 toggles low
    {1'b0, 8'h00, 8'd8, 1'b1, 4'd7},  // R7 toggles high
    {1'b1, 8'h0A, 8'd0, 1'b0, 4'd5},  // R5 key ends alarm
    {1'b0, 8'h00, 8'd7, 1'b0, 4'd5},
    {1'b1, 8'h1A, 8'd0, 1'b0, 4'd6},  // R6 bit 4 wrong
    {1'b1, 8'h4A, 8'd0, 1'b0, 4'd6},  // R6 later good key cancels
    {1'b0, 8'h00, 8'd7, 1'b0, 4'd6},
    {1'b0, 8'h00, 8'd1, 1'b1, 4'd4},  // R4 expiry
    {1'b1, 8'h00, 8'd0, 1'b1, 4'd6},  // R6 bad key during alarm
    {1'b0, 8'h00, 8'd8, 1'b0, 4'd7}   // R7 toggling not restarted
  };

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_in = 1'b1;
      repeat (6) @(negedge clk);
      tick_in = 1'b0;
      repeat (6) @(negedge clk);
    end
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    check(wd, 1'b1, "R1 wd in reset");
    check(wr_ready, 1'b0, "R1 ready in reset");
    #2;
    rst_n = 1'b1;
    #1;
    check(wd, 1'b0, "R2 wd drops at release");
    check(wr_ready, 1'b1, "R8 ready out of reset");
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][21]) write(VEC[v][20:13]);
      else            ticks(int'(VEC[v][12:5]));
      tag = $sformatf("R%0d vector %0d", VEC[v][3:0], v);
      check(wd, VEC[v][4], tag);
    end
    check(wr_ready, 1'b1, "R8 ready after traffic");

    // R1 asynchronous assertion and ignored writes while in reset
    #2;
    rst_n = 1'b0;
    #1;
    check(wd, 1'b1, "R1 wd rises at once");
    check(wr_ready, 1'b0, "R1 ready low");
    write(8'h0A);
    ticks(3);
    check(wd, 1'b1, "R1 wd held in reset");
    @(negedge clk);
    #2;
    rst_n = 1'b1;
    #1;
    check(wd, 1'b0, "R2 wd low on release");
    repeat (2) @(negedge clk);
    ticks(7);
    check(wd, 1'b0, "R2 count from zero");

    // R3 level high and rising edge do not count
    tick_in = 1'b1;
    repeat (40) @(negedge clk);
    check(wd, 1'b0, "R3 high level ignored");
    tick_in = 1'b0;
    repeat (6) @(negedge clk);
    check(wd, 1'b1, "R3 falling edge counts");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule